// File: doc/BRIEF.md
# Receive Slip Buffer with Selectable Depth

This block is a dual-clock elastic store for a serial 1.544 Mbit/s receive path. Bits arrive with a frame marker on the recovered line clock. They leave, still paired with their marker, on the system receive clock. The store absorbs the wander and jitter between the two clocks. The write and read positions cross between the clock domains in Gray code.

A 2-bit size select sets the active depth. The choices are two frames, one frame or a half frame; a fourth code passes the input straight through to the output. When the read position comes within a guard distance of either end of the occupied region, the block slips. A slip either re-reads stored bits or skips stored bits, and moves the read position back to the centre depth for the selected size. Each kind of slip sets its own sticky flag. In two-frame mode a slip moves the read position by exactly one frame, so the bit position within the frame is kept. When the select changes, the store empties and reading starts again at the new centre depth.

Top module: `rx_slip_buffer`

## Requirements
- R1: Select code 2'b00 gives a 386-bit store. After reset, with both sides enabled every cycle on equal clocks, reading begins once 193 bits are queued. The first frame marker then leaves between 193 and 199 read cycles after it was written.
- R2: Select code 2'b01 gives a 193-bit store, and the same first-marker latency lies between 96 and 102 cycles.
- R3: Select code 2'b10 gives a 96-bit store, and the same first-marker latency lies between 48 and 54 cycles.
- R4: Select code 2'b11 is pass-through. rd_data and rd_frame equal wr_data and wr_frame within the same cycle, and neither slip flag is ever set.
- R5: With equal rates, the bits leave in the order they were written. Within a frame, the bit at position p equals the bit written at position p. Read markers (rd_frame high) are 193 reads apart.
- R6: When the writer is faster than the reader, the block skips stored bits once the fill exceeds the size minus 8. slip_drop becomes 1 and stays 1 until reset, and slip_repeat stays 0.
- R7: When the writer is slower than the reader, the block re-reads stored bits once the fill falls below 8. slip_repeat becomes 1 and stays 1 until reset, and slip_drop stays 0.
- R8: In two-frame mode every slip moves the read position by one whole 193-bit frame. The read markers stay 193 reads apart across slips, and every bit stays at its frame position.
- R9: Changing the select without a reset empties the store. Reading restarts at the centre depth of the new size, with no slip flagged.
- R10: After reset, rd_data, rd_frame, slip_repeat and slip_drop are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered line clock |
| wr_rst_n | input | 1 | Active-low reset, line domain |
| wr_en | input | 1 | A bit is present on wr_data this cycle |
| wr_data | input | 1 | Received serial bit |
| wr_frame | input | 1 | Marks the first bit of a frame |
| rd_clk | input | 1 | System receive clock |
| rd_rst_n | input | 1 | Active-low reset, system domain |
| rd_en | input | 1 | Request one bit on the read side |
| size_sel | input | 2 | 00 two frames, 01 one frame, 10 half frame, 11 pass-through |
| rd_data | output | 1 | Delivered bit, registered except in pass-through |
| rd_frame | output | 1 | Frame marker travelling with rd_data |
| slip_repeat | output | 1 | Sticky: a slip re-read stored bits |
| slip_drop | output | 1 | Sticky: a slip skipped stored bits |

## Verification
The hardest case to reach from the ports is a slip, because the fill level has to drift all the way from the centre to the guard distance. The bench produces this with rate patterns in which one side runs at two thirds of the other's rate for thousands of cycles. Each buffer size then slips several times. For the two-frame rows, the bench follows the frame position of every delivered bit across these slips. It also checks every marker spacing, so any slip that is not exactly one frame long shows up as an alignment error.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  typedef enum logic [1:0] {
    SZ_TWO    = 2'b00,
    SZ_ONE    = 2'b01,
    SZ_HALF   = 2'b10,
    SZ_BYPASS = 2'b11
  } size_e;

  // Active store length in bits for a size code
  function automatic int unsigned depth_of(input size_e s, input int unsigned frame);
    case (s)
      SZ_ONE:  return frame;
      SZ_HALF: return frame / 2;
      default: return 2 * frame;
    endcase
  endfunction

  // Fill level targeted at start and after every slip
  function automatic int unsigned centre_of(input size_e s, input int unsigned frame);
    case (s)
      SZ_ONE:  return frame / 2;
      SZ_HALF: return frame / 4;
      default: return frame;
    endcase
  endfunction

  function automatic logic [15:0] to_gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [15:0] from_gray(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Move forward by d on a ring of n entries
  function automatic logic [15:0] ring_fwd(input logic [15:0] a, input logic [15:0] d,
                                          input logic [15:0] n);
    logic [15:0] s;
    s = a + d;
    return (s >= n) ? s - n : s;
  endfunction

  // Move backward by d on a ring of n entries
  function automatic logic [15:0] ring_back(input logic [15:0] a, input logic [15:0] d,
                                           input logic [15:0] n);
    return (a >= d) ? a - d : a + n - d;
  endfunction

endpackage

// File: rtl/rsb_sync.sv
module rsb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= '0;
        else        st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/rsb_wr_side.sv
module rsb_wr_side import rsb_pkg::*; #(
  parameter int FRAME = 193,
  parameter int PW    = 9,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    sel_raw,
  output logic          we,
  output logic [PW-1:0] waddr,
  output logic [PW-1:0] wgray
);
  logic [1:0]    sel_s, sel_q;
  logic          flush, bypass;
  size_e         sz;
  logic [PW-1:0] depth, wcnt, wcnt_nx, waddr_nx;

  rsb_sync #(.W(2), .STAGES(SYNC)) u_sel (.clk(clk), .rst_n(rst_n), .d(sel_raw), .q(sel_s));

  assign sz       = size_e'(sel_s);
  assign flush    = (sel_s != sel_q);
  assign bypass   = (sz == SZ_BYPASS);
  assign depth    = PW'(depth_of(sz, FRAME));
  assign we       = en && !bypass && !flush;
  assign wcnt_nx  = wcnt + 1'b1;
  assign waddr_nx = (waddr == depth - 1'b1) ? '0 : waddr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      wcnt  <= '0;
      waddr <= '0;
      wgray <= '0;
    end else begin
      sel_q <= sel_s;
      if (flush) begin
        wcnt  <= '0;
        waddr <= '0;
        wgray <= '0;
      end else if (we) begin
        wcnt  <= wcnt_nx;
        waddr <= waddr_nx;
        wgray <= PW'(to_gray(16'(wcnt_nx)));
      end
    end
  end

  // R2
  waddr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (waddr < depth));
endmodule

// File: rtl/rsb_rd_side.sv
module rsb_rd_side import rsb_pkg::*; #(
  parameter int FRAME = 193,
  parameter int PW    = 9,
  parameter int GUARD = 8,
  parameter int SYNC  = 2,
  parameter int HOLD  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    sel_raw,
  input  logic [PW-1:0] wgray_async,
  output logic          re,
  output logic [PW-1:0] raddr,
  output logic          bypass,
  output logic          slip_repeat,
  output logic          slip_drop
);
  localparam int HW = $clog2(HOLD + 1);

  logic [1:0]    sel_s, sel_q;
  logic          flush, started, start_now, under, over;
  size_e         sz;
  logic [HW-1:0] hold;
  logic [PW-1:0] depth, centre, wsync, wbin, rcnt, fill;
  logic [PW-1:0] raddr_step, raddr_nx, rcnt_nx;

  rsb_sync #(.W(2),  .STAGES(SYNC)) u_sel  (.clk(clk), .rst_n(rst_n), .d(sel_raw),     .q(sel_s));
  rsb_sync #(.W(PW), .STAGES(SYNC)) u_wptr (.clk(clk), .rst_n(rst_n), .d(wgray_async), .q(wsync));

  assign sz     = size_e'(sel_s);
  assign flush  = (sel_s != sel_q);
  assign bypass = (sz == SZ_BYPASS);
  assign depth  = PW'(depth_of(sz, FRAME));
  assign centre = PW'(centre_of(sz, FRAME));
  assign wbin   = PW'(from_gray(16'(wsync)));
  assign fill   = wbin - rcnt;

  // Named events used by the checks below
  assign start_now = !started && !flush && !bypass && (hold == '0) && (fill >= centre);
  assign re        = en && (started || start_now) && !flush && !bypass;
  assign under     = re && started && (fill < PW'(GUARD));
  assign over      = re && started && (fill > depth - PW'(GUARD));

  assign raddr_step = (raddr == depth - 1'b1) ? '0 : raddr + 1'b1;
  always_comb begin
    raddr_nx = raddr_step;
    rcnt_nx  = rcnt + 1'b1;
    if (under) begin
      raddr_nx = PW'(ring_back(16'(raddr_step), 16'(centre), 16'(depth)));
      rcnt_nx  = rcnt + 1'b1 - centre;
    end else if (over) begin
      raddr_nx = PW'(ring_fwd(16'(raddr_step), 16'(centre), 16'(depth)));
      rcnt_nx  = rcnt + 1'b1 + centre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= '0;
      rcnt        <= '0;
      raddr       <= '0;
      started     <= 1'b0;
      hold        <= HW'(HOLD);
      slip_repeat <= 1'b0;
      slip_drop   <= 1'b0;
    end else begin
      sel_q <= sel_s;
      if (under) slip_repeat <= 1'b1;
      if (over)  slip_drop   <= 1'b1;
      if (flush) begin
        rcnt    <= '0;
        raddr   <= '0;
        started <= 1'b0;
        hold    <= HW'(HOLD);
      end else begin
        if (hold != '0) hold <= hold - 1'b1;
        if (start_now)  started <= 1'b1;
        if (re) begin
          rcnt  <= rcnt_nx;
          raddr <= raddr_nx;
        end
      end
    end
  end

  // R1
  raddr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (raddr < depth));
  // R7
  repeat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    under |=> slip_repeat);
  // R6
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over |=> slip_drop);
  // R7
  repeat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_repeat |=> slip_repeat);
  // R6
  drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_drop |=> slip_drop);
endmodule

// File: rtl/rx_slip_buffer.sv
module rx_slip_buffer import rsb_pkg::*; #(
  parameter int FRAME_BITS  = 193,
  parameter int GUARD_BITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       wr_clk,
  input  logic       wr_rst_n,
  input  logic       wr_en,
  input  logic       wr_data,
  input  logic       wr_frame,
  input  logic       rd_clk,
  input  logic       rd_rst_n,
  input  logic       rd_en,
  input  logic [1:0] size_sel,
  output logic       rd_data,
  output logic       rd_frame,
  output logic       slip_repeat,
  output logic       slip_drop
);
  localparam int STORE = 2 * FRAME_BITS;
  localparam int PW    = $clog2(STORE);

  logic          we, re, rd_bypass;
  logic [PW-1:0] waddr, raddr, wgray;
  logic [1:0]    store [STORE];
  logic [1:0]    q;

  rsb_wr_side #(.FRAME(FRAME_BITS), .PW(PW), .SYNC(SYNC_STAGES)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .en(wr_en), .sel_raw(size_sel),
    .we(we), .waddr(waddr), .wgray(wgray));

  rsb_rd_side #(.FRAME(FRAME_BITS), .PW(PW), .GUARD(GUARD_BITS), .SYNC(SYNC_STAGES)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .en(rd_en), .sel_raw(size_sel), .wgray_async(wgray),
    .re(re), .raddr(raddr), .bypass(rd_bypass),
    .slip_repeat(slip_repeat), .slip_drop(slip_drop));

  always_ff @(posedge wr_clk)
    if (we) store[waddr] <= {wr_frame, wr_data};

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) q <= 2'b00;
    else           q <= re ? store[raddr] : 2'b00;

  assign rd_data  = rd_bypass ? wr_data  : q[0];
  assign rd_frame = rd_bypass ? wr_frame : q[1];
endmodule

// File: tb/sim_rx_slip_buffer.sv
module sim_rx_slip_buffer;
  localparam int FRAME = 193;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_data = 1'b0, wr_frame = 1'b0, rd_en = 1'b0;
  logic [1:0] size_sel = 2'b00;
  logic rd_data, rd_frame, slip_repeat, slip_drop;

  int total = 0, bad = 0;
  int lat, wfirst, align_err, seen_mark;

  always #5 clk = ~clk;

  rx_slip_buffer u0 (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_frame(wr_frame),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en), .size_sel(size_sel),
    .rd_data(rd_data), .rd_frame(rd_frame), .slip_repeat(slip_repeat), .slip_drop(slip_drop));

  // Row: {sel[1:0], writer slow, reader slow, expect repeat, expect drop, check order, check latency}
  localparam logic [7:0] ROWS [7] = '{
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic pat(input int p);
    return p[0] ^ p[2] ^ p[4] ^ p[7];
  endfunction

  function automatic int mid_of(input logic [1:0] s);
    return (s == 2'b00) ? FRAME : (s == 2'b01) ? FRAME / 2 : FRAME / 4;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; size_sel = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic stream(input int n, input bit wslow, input bit rslow);
    bit rd_prev = 1'b0;
    int wp = 0, rp = 0;
    seen_mark = 0; lat = -1; wfirst = -1; align_err = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rd_prev) begin
        if (seen_mark == 0) begin
          if (rd_frame) begin
            seen_mark = 1; rp = 0; lat = (i - 1) - wfirst;
            if (rd_data !== pat(0)) align_err++;
          end
        end else begin
          rp = (rp + 1) % FRAME;
          if (rd_frame !== (rp == 0)) align_err++;
          if (rd_data !== pat(rp)) align_err++;
        end
      end
      wr_en = !(wslow && (i % 3 == 0));
      rd_en = !(rslow && (i % 3 == 0));
      if (wr_en) begin
        wr_frame = (wp == 0);
        wr_data  = pat(wp);
        if (wfirst < 0) wfirst = i;
        wp = (wp + 1) % FRAME;
      end
      rd_prev = rd_en;
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10 reset state
    do_reset(2'b00);
    check(rd_data == 1'b0,     "R10", "rd_data",     int'(rd_data), 0);
    check(rd_frame == 1'b0,    "R10", "rd_frame",    int'(rd_frame), 0);
    check(slip_repeat == 1'b0, "R10", "slip_repeat", int'(slip_repeat), 0);
    check(slip_drop == 1'b0,   "R10", "slip_drop",   int'(slip_drop), 0);

    // Vector table walk: R1 R2 R3 R5 R6 R7 R8
    for (int r = 0; r < 7; r++) begin
      logic [7:0] v = ROWS[r];
      int mid = mid_of(v[7:6]);
      do_reset(v[7:6]);
      stream(4000, v[5], v[4]);
      repeat (20) @(negedge clk);
      check(slip_repeat == v[3], "R7", "slip_repeat", int'(slip_repeat), int'(v[3]));
      check(slip_drop == v[2],   "R6", "slip_drop",   int'(slip_drop),   int'(v[2]));
      if (v[1]) begin
        check(seen_mark == 1 && align_err == 0, (v[3] || v[2]) ? "R8" : "R5",
              "order errors", align_err, 0);
      end
      if (v[0]) begin
        check(lat >= mid && lat <= mid + 6,
              (v[7:6] == 2'b00) ? "R1" : (v[7:6] == 2'b01) ? "R2" : "R3",
              "first marker latency", lat, mid + 2);
      end
    end

    // R4 pass-through
    do_reset(2'b11);
    for (int k = 0; k < 4; k++) begin
      wr_data = k[0]; wr_frame = k[1];
      #1;
      check(rd_data == wr_data,   "R4", "bypass data",  int'(rd_data),  int'(wr_data));
      check(rd_frame == wr_frame, "R4", "bypass frame", int'(rd_frame), int'(wr_frame));
      @(negedge clk);
    end
    stream(600, 1'b1, 1'b0);
    check(!slip_repeat && !slip_drop, "R4", "flags in bypass",
          int'({slip_repeat, slip_drop}), 0);

    // R9 size change without reset
    do_reset(2'b00);
    stream(800, 1'b0, 1'b0);
    size_sel = 2'b10;
    repeat (15) @(negedge clk);
    stream(600, 1'b0, 1'b0);
    check(lat >= 48 && lat <= 54, "R9", "latency after size change", lat, 50);
    check(seen_mark == 1 && align_err == 0, "R9", "order after size change", align_err, 0);
    check(!slip_repeat && !slip_drop, "R9", "no slip after size change",
          int'({slip_repeat, slip_drop}), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule